// File: doc/BRIEF.md
# Mode-Gated Interrupt Priority Selector

This block keeps one pending bit for each of seven interrupt sources and chooses the single source the trap logic must service next. Devices raise a pending bit through a set pulse. Architectural events drop it again: a write to the hypervisor-interrupt status, an access to the interrupt-vector space, the fall of the trap-level-zero mode flag, or a generic per-source clear.

The choice depends on two mode inputs. One is the hypervisor-privilege bit and the other is the global interrupt enable. In hypervisor mode, only two sources can be delivered, and only when the enable is set. Outside hypervisor mode, three sources are delivered without regard to the enable. The other four sources are delivered only when the enable is set.

The pending bits are registered. The selection is purely combinational from those bits and the two mode inputs. A change of mode or enable therefore changes the result in the same cycle. The trap logic reads `irq_valid_o` and `irq_src_o`. It may raise `take_i` to claim the interrupt. A claim made while nothing can be delivered is flagged on `take_err_o`.

Top module: `irq_mode_selector`

## Requirements
- R1: A synchronous active-high reset clears every pending bit and the stored mode flag history. After reset, `pend_o` is 0, `any_pend_o` is 0 and `irq_valid_o` is 0.
- R2: A set pulse on `set_i[k]` makes `pend_o[k]` 1 after the next rising clock edge. A set on a bit wins over any clear of that bit in the same cycle.
- R3: With no set on bit k in the same cycle, `clr_i[k]` clears `pend_o[k]` at the next edge. Bits that are neither set nor cleared keep their value.
- R4: With no set on the same bit, `hint_wr_i` clears source 1 at the next edge. With no set on the same bit, `ivec_acc_i` clears source 2 at the next edge. Each of these two inputs touches no other source.
- R5: Source 0 is cleared at an edge where `tlz_flag_i` was 1 at the previous edge and is 0 now. A level that stays low or stays high does not clear it.
- R6: When `pend_o` is 0, `irq_valid_o` is 0 whatever the mode inputs are.
- R7: When `hpriv_i`=1 and `ie_i`=0, `irq_valid_o` is 0.
- R8: When `hpriv_i`=1 and `ie_i`=1, source 1 is selected before source 2. Sources 0 and 3 to 6 are never selected in this mode.
- R9: When `hpriv_i`=0, sources 0, 1 and 2 are selected in that order, whatever the value of `ie_i`.
- R10: When `hpriv_i`=0 and `ie_i`=1, sources 3, 4, 5 and 6 follow in that order, after sources 0 to 2. When `ie_i`=0, these four sources are never selected.
- R11: `irq_src_o` uses this encoding: 0 trap-level-zero, 1 hypervisor interrupt, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 soft interrupt, 6 resumable error. Bit k of `set_i`, `clr_i` and `pend_o` belongs to source k.
- R12: A change of `hpriv_i` or `ie_i` changes `irq_valid_o` and `irq_src_o` in the same cycle, with no clock edge in between.
- R13: `take_err_o` is 1 exactly when `take_i`=1 and `irq_valid_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_i | input | 7 | Per-source set pulses from devices |
| clr_i | input | 7 | Per-source generic clear pulses |
| tlz_flag_i | input | 1 | Trap-level-zero mode flag; its fall clears source 0 |
| hint_wr_i | input | 1 | Hypervisor-interrupt status write; clears source 1 |
| ivec_acc_i | input | 1 | Interrupt-vector space access; clears source 2 |
| hpriv_i | input | 1 | Hypervisor-privilege mode |
| ie_i | input | 1 | Global interrupt enable |
| take_i | input | 1 | Trap logic claims the selected interrupt |
| pend_o | output | 7 | Registered pending bits |
| any_pend_o | output | 1 | OR of all pending bits |
| irq_valid_o | output | 1 | An interrupt is deliverable now |
| irq_src_o | output | 3 | Encoded identifier of the selected source |
| take_err_o | output | 1 | Claim made while nothing is deliverable |

## Verification
The assertions assume that every input is a clean level at each rising edge. They also assume that set pulses are held low while reset is high, so the one-cycle set-to-pending property never spans the reset release. The stimulus drives all inputs only on falling edges and keeps `set_i` at zero during every reset window. It varies `hpriv_i` and `ie_i` every cycle, so that combinational mode changes meet every mix of pending bits. The mix of sparse sets, clears, flag toggles and claims is chosen to reach empty, single and crowded pending states.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int NUM_SRC = 7;
    localparam int SRC_W   = $clog2(NUM_SRC);

    typedef enum logic [SRC_W-1:0] {
        SRC_TLZ  = 3'd0,
        SRC_HINT = 3'd1,
        SRC_IVEC = 3'd2,
        SRC_CPUM = 3'd3,
        SRC_DEVM = 3'd4,
        SRC_SOFT = 3'd5,
        SRC_RERR = 3'd6
    } src_id_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic    valid;
        src_id_e id;
    } pick_t;

    function automatic src_vec_t bit_of(input src_id_e s);
        return src_vec_t'(1) << s;
    endfunction

    // sources deliverable in hypervisor mode (enable required)
    localparam src_vec_t HPRIV_GATED = bit_of(SRC_HINT) | bit_of(SRC_IVEC);
    // sources deliverable outside hypervisor mode without the enable
    localparam src_vec_t USER_FREE   = bit_of(SRC_TLZ) | bit_of(SRC_HINT) | bit_of(SRC_IVEC);
    // sources deliverable outside hypervisor mode only with the enable
    localparam src_vec_t USER_GATED  = bit_of(SRC_CPUM) | bit_of(SRC_DEVM)
                                     | bit_of(SRC_SOFT) | bit_of(SRC_RERR);

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                pend_o[k] <= 1'b0;
            else if (set_i[k])
                pend_o[k] <= 1'b1;
            else if (clr_i[k])
                pend_o[k] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_mode_mask.sv
module irq_mode_mask
    import irq_sel_pkg::*;
(
    input  logic     hpriv_i,
    input  logic     ie_i,
    output src_vec_t elig_o
);
    always_comb begin
        if (hpriv_i)
            elig_o = ie_i ? HPRIV_GATED : '0;
        else
            elig_o = USER_FREE | (ie_i ? USER_GATED : '0);
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 7,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic         valid_o,
    output logic [W-1:0] idx_o
);
    // lowest index carries the highest priority
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                valid_o = 1'b1;
                idx_o   = W'(k);
            end
        end
    end
endmodule

// File: rtl/irq_mode_selector.sv
module irq_mode_selector
    import irq_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               tlz_flag_i,
    input  logic               hint_wr_i,
    input  logic               ivec_acc_i,
    input  logic               hpriv_i,
    input  logic               ie_i,
    input  logic               take_i,
    output logic [NUM_SRC-1:0] pend_o,
    output logic               any_pend_o,
    output logic               irq_valid_o,
    output logic [SRC_W-1:0]   irq_src_o,
    output logic               take_err_o
);
    logic     tlz_q;
    logic     tlz_fall;
    src_vec_t clr_all;
    src_vec_t elig;
    pick_t    pick;
    logic [SRC_W-1:0] pick_idx;

    always_ff @(posedge clk) begin
        if (rst) tlz_q <= 1'b0;
        else     tlz_q <= tlz_flag_i;
    end

    assign tlz_fall = tlz_q & ~tlz_flag_i;

    assign clr_all = clr_i
                   | (tlz_fall   ? bit_of(SRC_TLZ)  : '0)
                   | (hint_wr_i  ? bit_of(SRC_HINT) : '0)
                   | (ivec_acc_i ? bit_of(SRC_IVEC) : '0);

    irq_pend_bank #(.N(NUM_SRC)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_i),
        .clr_i  (clr_all),
        .pend_o (pend_o)
    );

    irq_mode_mask u_mask (
        .hpriv_i (hpriv_i),
        .ie_i    (ie_i),
        .elig_o  (elig)
    );

    irq_prio_pick #(.N(NUM_SRC)) u_pick (
        .req_i   (pend_o & elig),
        .valid_o (pick.valid),
        .idx_o   (pick_idx)
    );

    assign pick.id     = src_id_e'(pick_idx);
    assign any_pend_o  = |pend_o;
    assign irq_valid_o = pick.valid;
    assign irq_src_o   = pick.id;
    assign take_err_o  = take_i & ~pick.valid;
endmodule

// File: rtl/irq_mode_selector_chk.sv
module irq_mode_selector_chk
    import irq_sel_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] set_i,
    input logic               hpriv_i,
    input logic               ie_i,
    input logic               take_i,
    input logic [NUM_SRC-1:0] pend_o,
    input logic               irq_valid_o,
    input logic [SRC_W-1:0]   irq_src_o,
    input logic               take_err_o
);
    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

    // R6
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_o == '0) |-> !irq_valid_o);

    // R7
    hpriv_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (hpriv_i && !ie_i) |-> !irq_valid_o);

    // R8
    hpriv_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (hpriv_i && irq_valid_o) |-> (irq_src_o == 3'd1 || irq_src_o == 3'd2));

    // R9
    tlz_first_chk: assert property (@(posedge clk) disable iff (rst)
        (!hpriv_i && pend_o[0]) |-> (irq_valid_o && irq_src_o == 3'd0));

    // R10
    user_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!hpriv_i && !ie_i && irq_valid_o) |-> (irq_src_o <= 3'd2));

    // R11
    picked_pending_chk: assert property (@(posedge clk) disable iff (rst)
        irq_valid_o |-> pend_o[irq_src_o]);

    // R13
    bad_take_chk: assert property (@(posedge clk) disable iff (rst)
        (take_i && !irq_valid_o) |-> take_err_o);
endmodule

bind irq_mode_selector irq_mode_selector_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .set_i       (set_i),
    .hpriv_i     (hpriv_i),
    .ie_i        (ie_i),
    .take_i      (take_i),
    .pend_o      (pend_o),
    .irq_valid_o (irq_valid_o),
    .irq_src_o   (irq_src_o),
    .take_err_o  (take_err_o)
);

// File: tb/irq_mode_selector_test.sv
module irq_mode_selector_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [6:0] set_i, clr_i;
    logic       tlz_flag_i, hint_wr_i, ivec_acc_i, hpriv_i, ie_i, take_i;
    logic [6:0] pend_o;
    logic       any_pend_o, irq_valid_o, take_err_o;
    logic [2:0] irq_src_o;

    always #2 clk = ~clk;   // 250 MHz

    irq_mode_selector uut (.*);

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    // behavioural reference state
    bit [6:0] m_pend;
    bit       m_tlz;

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // expected selection written as the rule list, first match wins
    task automatic expect_sel(output bit v, output int id, output string tag);
        v = 0; id = 0; tag = "R6";
        if (m_pend == 0) return;
        if (hpriv_i) begin
            tag = ie_i ? "R8" : "R7";
            if (ie_i) begin
                if (m_pend[1])      begin v = 1; id = 1; end
                else if (m_pend[2]) begin v = 1; id = 2; end
            end
        end else begin
            tag = "R9";
            if (m_pend[0])      begin v = 1; id = 0; end
            else if (m_pend[1]) begin v = 1; id = 1; end
            else if (m_pend[2]) begin v = 1; id = 2; end
            else begin
                tag = "R10";
                if (ie_i) begin
                    if (m_pend[3])      begin v = 1; id = 3; end
                    else if (m_pend[4]) begin v = 1; id = 4; end
                    else if (m_pend[5]) begin v = 1; id = 5; end
                    else if (m_pend[6]) begin v = 1; id = 6; end
                end
            end
        end
    endtask

    task automatic compare_all();
        bit v; int id; string tag;
        expect_sel(v, id, tag);
        chk("R1 R2 R3 R4 R5 pend", int'(pend_o), int'(m_pend));
        chk("R1 any_pend", int'(any_pend_o), int'(m_pend != 0));
        chk({tag, " R12 valid"}, int'(irq_valid_o), int'(v));
        if (v) chk({tag, " R11 src"}, int'(irq_src_o), id);
        chk("R13 take_err", int'(take_err_o), int'(take_i && !v));
    endtask

    task automatic model_edge();
        bit [6:0] c;
        if (rst) begin
            m_pend = 0; m_tlz = 0;
            return;
        end
        c = clr_i;
        if (m_tlz && !tlz_flag_i) c[0] = 1;
        if (hint_wr_i)  c[1] = 1;
        if (ivec_acc_i) c[2] = 1;
        m_pend = (m_pend & ~c) | set_i;
        m_tlz  = tlz_flag_i;
    endtask

    task automatic step(input bit r, input bit [6:0] s, input bit [6:0] c, input bit tf,
                        input bit hw, input bit ia, input bit hp, input bit ie, input bit tk);
        @(negedge clk);
        rst = r; set_i = s; clr_i = c; tlz_flag_i = tf; hint_wr_i = hw;
        ivec_acc_i = ia; hpriv_i = hp; ie_i = ie; take_i = tk;
        #1 if (!r) compare_all();
        @(posedge clk);
        model_edge();
    endtask

    initial begin
        rst = 1; set_i = 0; clr_i = 0; tlz_flag_i = 0; hint_wr_i = 0;
        ivec_acc_i = 0; hpriv_i = 0; ie_i = 0; take_i = 0;
        m_pend = 0; m_tlz = 0;
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0, 0, 0);
        #1;
        // R1: reset state
        chk("R1 pend after reset", int'(pend_o), 0);
        chk("R1 valid after reset", int'(irq_valid_o), 0);

        // R11: encoding, each source alone, user mode with enable
        for (int k = 0; k < 7; k++) begin
            step(0, 0, 7'h7f, 0, 0, 0, 0, 1, 0);
            step(0, 7'(1 << k), 0, 0, 0, 0, 0, 1, 0);
            #1;
            chk("R11 lone source id", int'(irq_src_o), k);
        end

        // R2: set beats clear on the same bit
        step(0, 7'h08, 7'h7f, 0, 0, 0, 0, 1, 0);
        #1 chk("R2 set wins", int'(pend_o), 8'h08);

        // R4: hint write and vector access clear only their own bits
        step(0, 7'h7f, 0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 1, 1, 0, 1, 0);
        #1 chk("R4 targeted clears", int'(pend_o), 7'h79);

        // R5: flag held high, then falling
        step(0, 0, 0, 1, 0, 0, 0, 1, 0);
        step(0, 0, 0, 1, 0, 0, 0, 1, 0);
        #1 chk("R5 high flag keeps bit", int'(pend_o[0]), 1);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0);
        #1 chk("R5 fall clears bit", int'(pend_o[0]), 0);

        // R12: mode flips with HINT and CPU mondo pending
        step(0, 7'h0a, 7'h75, 0, 0, 0, 1, 1, 0);
        step(0, 0, 0, 0, 0, 0, 1, 0, 1);   // R7 and R13 via model
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);   // R9
        step(0, 0, 7'h02, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 1);   // R10 CPU mondo
        step(0, 0, 0, 0, 0, 0, 1, 1, 1);   // R8 ignores it

        // randomized traffic with occasional reset
        for (int n = 0; n < 3000; n++) begin
            bit [6:0] s, c;
            bit rr;
            rr = ($urandom % 200) == 0;
            s  = rr ? 7'h0 : 7'($urandom) & 7'($urandom) & 7'($urandom);
            c  = 7'($urandom) & 7'($urandom);
            step(rr, s, c, ($urandom % 4) != 0 ? m_tlz : 1'($urandom),
                 ($urandom % 6) == 0, ($urandom % 6) == 0,
                 1'($urandom), 1'($urandom), 1'($urandom));
        end

        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end
endmodule